// File: doc/BRIEF.md
# NAND Page ECC Syndrome Checker

This block decides whether a 512-byte chunk read back from flash is intact. It takes the 24-bit parity just computed over the data and the 24-bit parity saved with the page. It XORs them into a syndrome and sorts the result into one of four outcomes:

- the data and its code agree;
- one data bit has flipped, and the block can point to it;
- the stored code itself was hit, and the data is good;
- the damage is beyond repair.

For the flipped-bit case the block reports which byte and which bit went bad. A caller streaming the chunk can also hand over a data byte with its address. When the addresses match and repair is enabled, the block returns that byte already corrected.

The parity words are arranged as twelve odd/even pairs. Pair k covers the parity of weight 2^k. Its odd member sits at syndrome bit 2k+1 and its even member at bit 2k. Inputs arrive under a valid/ready handshake. Each accepted input produces a registered result one cycle later, so a new word can be accepted on every clock.

Top module: `ecc_syndrome_check`

## Requirements
- R1: When calc_ecc XOR stored_ecc is zero, status is 00 and err_addr and err_bit are zero.
- R2: The syndrome is viewed as twelve pairs: bit 2k+1 is the odd member of pair k and bit 2k is the even member. When every pair has exactly one member set, status is 01 (data bit error).
- R3: For status 01 the 12-bit location is built from the odd members, with pair 11 as MSB and pair 0 as LSB. err_addr is location bits [11:3] and err_bit is location bits [2:0].
- R4: When the syndrome has exactly one bit set, status is 10 (code-field error), and out_byte equals data_byte.
- R5: Every other non-zero syndrome gives status 11 (uncorrectable).
- R6: Whenever status is not 01, err_addr and err_bit are zero.
- R7: Repair happens when fix_en is 1, status is 01 and data_addr equals err_addr. In that case out_byte is data_byte with bit err_bit inverted, where bit 0 is the LSB.
- R8: In every other case out_byte equals data_byte unchanged. This includes a wrong address, fix_en low, or any status other than 01.
- R9: An input is accepted when in_valid and in_ready are both 1. Its results appear with out_valid high on the next clock edge. out_valid is low after any cycle without an acceptance. Back-to-back acceptances give back-to-back results.
- R10: While rst_n is low, in_ready, out_valid, status, err_addr, err_bit and out_byte are all zero. in_ready rises on the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take an input |
| calc_ecc | input | 24 | Parity computed over the data |
| stored_ecc | input | 24 | Parity saved with the page |
| fix_en | input | 1 | Allow repair of data_byte |
| data_addr | input | 9 | Byte address of data_byte within the chunk |
| data_byte | input | 8 | Data byte offered for repair |
| out_valid | output | 1 | Registered result present |
| status | output | 2 | 00 clean, 01 data bit, 10 code field, 11 uncorrectable |
| err_addr | output | 9 | Byte address of the flipped bit |
| err_bit | output | 3 | Bit index of the flipped bit within its byte |
| out_byte | output | 8 | Repaired or passed-through byte |

## Verification
The bench hits both ends of the location range (byte 0 bit 0, and byte 511 bit 7). A design that swapped the odd and even members, or reversed the pair order, would report the wrong byte or bit there. Single-bit syndromes at the lowest bit, the highest bit and a middle bit check that the code-field case is kept apart from the uncorrectable one. Syndromes with a pair fully set, or with two data errors, check that only the strict one-of-each-pair pattern counts as repairable. Repair is tried with a matching address, a wrong address, repair disabled, and a non-01 status; a design that flipped bits too eagerly would corrupt good bytes in those cases. Back-to-back inputs and idle gaps show whether a result is late, duplicated or lost.

// File: rtl/ecc_cls_pkg.sv
package ecc_cls_pkg;
  typedef enum logic [1:0] {
    ST_CLEAN    = 2'b00,
    ST_DATA_FIX = 2'b01,
    ST_CODE_ERR = 2'b10,
    ST_FATAL    = 2'b11
  } ecc_status_e;
endpackage

// File: rtl/ecc_syndrome_gen.sv
module ecc_syndrome_gen #(
  parameter int PAIRS = 12,
  localparam int SYN_W = 2 * PAIRS
) (
  input  logic [SYN_W-1:0] calc_ecc,
  input  logic [SYN_W-1:0] stored_ecc,
  output logic [SYN_W-1:0] syn,
  output logic [PAIRS-1:0] pair_flip,
  output logic [PAIRS-1:0] odd_bits
);
  assign syn = calc_ecc ^ stored_ecc;

  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    assign pair_flip[k] = syn[2*k+1] ^ syn[2*k];
    assign odd_bits[k]  = syn[2*k+1];
  end
endmodule

// File: rtl/ecc_classifier.sv
module ecc_classifier
  import ecc_cls_pkg::*;
#(
  parameter int PAIRS = 12,
  localparam int SYN_W = 2 * PAIRS,
  localparam int WT_W  = $clog2(SYN_W + 1)
) (
  input  logic [SYN_W-1:0] syn,
  input  logic [PAIRS-1:0] pair_flip,
  output ecc_status_e      status,
  output logic [WT_W-1:0]  weight
);
  function automatic logic [WT_W-1:0] ones_of(input logic [SYN_W-1:0] v);
    logic [WT_W-1:0] n;
    n = '0;
    for (int i = 0; i < SYN_W; i++) n = n + WT_W'(v[i]);
    return n;
  endfunction

  always_comb begin
    weight = ones_of(syn);
    if (syn == '0)                  status = ST_CLEAN;
    else if (&pair_flip)            status = ST_DATA_FIX;
    else if (weight == WT_W'(1))    status = ST_CODE_ERR;
    else                            status = ST_FATAL;
  end
endmodule

// File: rtl/ecc_byte_fixer.sv
module ecc_byte_fixer #(
  parameter int ADDR_W    = 9,
  parameter int BIT_IDX_W = 3,
  localparam int BYTE_W   = 2 ** BIT_IDX_W
) (
  input  logic                 fix_en,
  input  logic                 is_fixable,
  input  logic [ADDR_W-1:0]    err_addr,
  input  logic [BIT_IDX_W-1:0] err_bit,
  input  logic [ADDR_W-1:0]    data_addr,
  input  logic [BYTE_W-1:0]    data_byte,
  output logic                 hit,
  output logic [BYTE_W-1:0]    out_byte
);
  logic [BYTE_W-1:0] flip_mask;

  assign hit       = fix_en & is_fixable & (data_addr == err_addr);
  assign flip_mask = BYTE_W'(1) << err_bit;
  assign out_byte  = hit ? (data_byte ^ flip_mask) : data_byte;
endmodule

// File: rtl/ecc_syndrome_check.sv
module ecc_syndrome_check
  import ecc_cls_pkg::*;
#(
  parameter int PAIRS     = 12,
  parameter int BIT_IDX_W = 3,
  localparam int SYN_W    = 2 * PAIRS,
  localparam int ADDR_W   = PAIRS - BIT_IDX_W,
  localparam int BYTE_W   = 2 ** BIT_IDX_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [SYN_W-1:0]     calc_ecc,
  input  logic [SYN_W-1:0]     stored_ecc,
  input  logic                 fix_en,
  input  logic [ADDR_W-1:0]    data_addr,
  input  logic [BYTE_W-1:0]    data_byte,
  output logic                 out_valid,
  output logic [1:0]           status,
  output logic [ADDR_W-1:0]    err_addr,
  output logic [BIT_IDX_W-1:0] err_bit,
  output logic [BYTE_W-1:0]    out_byte
);
  localparam int WT_W = $clog2(SYN_W + 1);

  // named internal events
  logic [SYN_W-1:0]     syn_w;
  logic [PAIRS-1:0]     pair_flip_w;
  logic [PAIRS-1:0]     odd_bits_w;
  ecc_status_e          class_w;
  logic [WT_W-1:0]      weight_w;
  logic                 accept_w;
  logic                 fixable_w;
  logic [ADDR_W-1:0]    loc_addr_w;
  logic [BIT_IDX_W-1:0] loc_bit_w;
  logic                 fix_hit_w;
  logic [BYTE_W-1:0]    fixed_byte_w;

  ecc_syndrome_gen #(.PAIRS(PAIRS)) u_gen (
    .calc_ecc   (calc_ecc),
    .stored_ecc (stored_ecc),
    .syn        (syn_w),
    .pair_flip  (pair_flip_w),
    .odd_bits   (odd_bits_w)
  );

  ecc_classifier #(.PAIRS(PAIRS)) u_cls (
    .syn       (syn_w),
    .pair_flip (pair_flip_w),
    .status    (class_w),
    .weight    (weight_w)
  );

  assign accept_w   = in_valid & in_ready;
  assign fixable_w  = (class_w == ST_DATA_FIX);
  assign loc_addr_w = fixable_w ? odd_bits_w[PAIRS-1:BIT_IDX_W] : '0;
  assign loc_bit_w  = fixable_w ? odd_bits_w[BIT_IDX_W-1:0]     : '0;

  ecc_byte_fixer #(.ADDR_W(ADDR_W), .BIT_IDX_W(BIT_IDX_W)) u_fix (
    .fix_en     (fix_en),
    .is_fixable (fixable_w),
    .err_addr   (loc_addr_w),
    .err_bit    (loc_bit_w),
    .data_addr  (data_addr),
    .data_byte  (data_byte),
    .hit        (fix_hit_w),
    .out_byte   (fixed_byte_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_ready  <= 1'b0;
      out_valid <= 1'b0;
      status    <= 2'b00;
      err_addr  <= '0;
      err_bit   <= '0;
      out_byte  <= '0;
    end else begin
      in_ready  <= 1'b1;
      out_valid <= accept_w;
      if (accept_w) begin
        status   <= class_w;
        err_addr <= loc_addr_w;
        err_bit  <= loc_bit_w;
        out_byte <= fixed_byte_w;
      end
    end
  end

  // R9: a result follows every acceptance by one cycle
  assert_result_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> out_valid);
  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_w |=> !out_valid);
  // R1: clean status only from a zero syndrome
  assert_clean_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && status == 2'b00) |-> ($past(syn_w) == '0));
  // R2: repairable status only when every pair contributed one bit
  assert_fix_weight_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && status == 2'b01) |-> ($countones($past(syn_w)) == PAIRS));
  // R4: code-field status only from a lone syndrome bit
  assert_code_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && status == 2'b10) |-> ($countones($past(syn_w)) == 1));
  // R6: location is zero unless repairable
  assert_loc_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && status != 2'b01) |-> (err_addr == '0 && err_bit == '0));
  // R7: repair never changes more than one bit
  assert_one_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_byte ^ $past(data_byte)) <= 1));
  // R8: repair disabled means pass-through
  assert_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(fix_en)) |-> (out_byte == $past(data_byte)));
endmodule

// File: tb/tb_ecc_syndrome_check.sv
`timescale 1ns/1ps
module tb_ecc_syndrome_check;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] calc_ecc = '0;
  logic [23:0] stored_ecc = '0;
  logic        fix_en = 1'b0;
  logic [8:0]  data_addr = '0;
  logic [7:0]  data_byte = '0;
  logic        out_valid;
  logic [1:0]  status;
  logic [8:0]  err_addr;
  logic [2:0]  err_bit;
  logic [7:0]  out_byte;

  always #2.5 clk = ~clk;

  ecc_syndrome_check dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .calc_ecc(calc_ecc), .stored_ecc(stored_ecc), .fix_en(fix_en),
    .data_addr(data_addr), .data_byte(data_byte), .out_valid(out_valid),
    .status(status), .err_addr(err_addr), .err_bit(err_bit), .out_byte(out_byte)
  );

  typedef struct {
    logic [1:0] st;
    logic [8:0] a;
    logic [2:0] b;
    logic [7:0] by;
    int         cyc;
    string      tag;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // independent reference: pair walk over the syndrome
  function automatic exp_t model(input logic [23:0] c, input logic [23:0] s,
                                 input logic fe, input logic [8:0] da, input logic [7:0] db);
    exp_t e;
    logic [23:0] x;
    logic [11:0] loc;
    int ones;
    bit every_pair;
    x = c ^ s;
    ones = 0;
    every_pair = 1;
    for (int k = 0; k < 12; k++) begin
      ones += int'(x[2*k]) + int'(x[2*k+1]);
      if (x[2*k] == x[2*k+1]) every_pair = 0;
      loc[k] = x[2*k+1];
    end
    e.a = '0; e.b = '0; e.by = db;
    if (x == 0)           e.st = 2'b00;
    else if (every_pair)  e.st = 2'b01;
    else if (ones == 1)   e.st = 2'b10;
    else                  e.st = 2'b11;
    if (e.st == 2'b01) begin
      e.a = loc[11:3];
      e.b = loc[2:0];
      if (fe && da == e.a) e.by = db ^ (8'h01 << loc[2:0]);
    end
    return e;
  endfunction

  function automatic logic [23:0] syn_at(input logic [11:0] loc);
    logic [23:0] x;
    for (int k = 0; k < 12; k++) begin
      x[2*k+1] = loc[k];
      x[2*k]   = ~loc[k];
    end
    return x;
  endfunction

  // driver: called just after a falling edge, leaves in_valid high
  task automatic send(input logic [23:0] c, input logic [23:0] x, input logic fe,
                      input logic [8:0] da, input logic [7:0] db, input string tag);
    exp_t e;
    calc_ecc = c; stored_ecc = c ^ x; fix_en = fe; data_addr = da; data_byte = db;
    in_valid = 1'b1;
    e = model(c, c ^ x, fe, da, db);
    e.cyc = cyc;
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && !done) begin
      if (q.size() == 0) begin
        check(0, "R9 unexpected out_valid", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(cyc == e.cyc + 1, {e.tag, " R9 latency"}, cyc - e.cyc, 1);
        check(status == e.st, {e.tag, " status"}, status, e.st);
        check(err_addr == e.a, {e.tag, " err_addr"}, err_addr, e.a);
        check(err_bit == e.b, {e.tag, " err_bit"}, err_bit, e.b);
        check(out_byte == e.by, {e.tag, " out_byte"}, out_byte, e.by);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      check(0, "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(in_ready == 1'b0, "R10 in_ready in reset", in_ready, 0);
    check(out_valid == 1'b0, "R10 out_valid in reset", out_valid, 0);
    check(status == 2'b00 && err_addr == 0 && err_bit == 0, "R10 status fields in reset",
          {status, err_addr, err_bit}, 0);
    check(out_byte == 8'h00, "R10 out_byte in reset", out_byte, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R10 in_ready after release", in_ready, 1);
    check(out_valid == 1'b0, "R9 idle out_valid", out_valid, 0);

    // R1 clean, several patterns
    send(24'h000000, 24'h0, 1'b1, 9'd0, 8'hA5, "R1 zero");
    send(24'hFFFFFF, 24'h0, 1'b1, 9'd0, 8'h3C, "R1 ones");
    send(24'h5A1C33, 24'h0, 1'b0, 9'd7, 8'h81, "R1 mixed");
    idle(2);

    // R2 R3 data-bit errors, location boundaries
    send(24'h123456, syn_at(12'h000), 1'b1, 9'd0,   8'h00, "R2 R3 R7 loc0");
    send(24'h0F0F0F, syn_at(12'hFFF), 1'b1, 9'd511, 8'hFF, "R2 R3 R7 loc max");
    send(24'hABCDEF, syn_at(12'h9A5), 1'b1, 9'h134, 8'h5A, "R2 R3 R7 mid");
    send(24'hABCDEF, syn_at(12'h9A5), 1'b1, 9'h135, 8'h5A, "R3 R8 wrong addr");
    send(24'h777777, syn_at(12'h2C3), 1'b0, 9'h058, 8'hC3, "R3 R8 fix off");
    idle(1);

    // R4 single-bit code errors
    send(24'h13579B, 24'h000001, 1'b1, 9'd0, 8'h11, "R4 R6 R8 low bit");
    send(24'h13579B, 24'h800000, 1'b1, 9'd0, 8'h22, "R4 R6 R8 high bit");
    send(24'h2468AC, 24'h000080, 1'b1, 9'd0, 8'h44, "R4 R6 R8 mid bit");

    // R5 uncorrectable patterns
    send(24'h000000, 24'h000003, 1'b1, 9'd0, 8'h66, "R5 R6 full pair");
    send(24'h111111, syn_at(12'h001) ^ syn_at(12'h002), 1'b1, 9'd0, 8'h77, "R5 two data errors");
    send(24'h000000, syn_at(12'h400) ^ 24'h000001, 1'b1, 9'h080, 8'h01, "R5 R8 pair missing");
    send(24'h000000, 24'h00000A, 1'b1, 9'd0, 8'h88, "R5 two odd bits");
    idle(3);

    // R9 gap then burst
    for (int i = 0; i < 6; i++) begin
      send(24'h0 + 24'(i * 24'h010203), syn_at(12'(i * 12'h155)), 1'b1,
           9'(i * 12'h155 >> 3), 8'(i * 37), "R3 R7 R9 burst");
    end
    idle(4);
    check(q.size() == 0, "R9 all results delivered", q.size(), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule